// File: doc/BRIEF.md
# Two-Channel Prescaled Pulse-Width Modulator

This block turns a small register set into two independent pulse-width modulated outputs. Each channel divides the source clock with a coded prescaler. The divided ticks drive a period counter, and the output is at its active level while that counter is below a programmed duty count. Software chooses the polarity, starts and stops each channel with two separate qualifier bits, and can switch the pin over to the raw source clock. In that raw mode every other setting is overridden.

Both channels share one control word, and each channel has its own period/duty word. A write to a period/duty word while the channel runs is parked in a shadow copy and applied at the next period boundary. A per-channel ready bit in the control word shows that an update is still waiting. The source clock is the only clock, and reads return data in the same cycle as the address.

Top module: `pwm2ch_ctrl`

## Requirements
- R1: Byte address 0x0 holds the control word, and address 0x4 + 4*n holds channel n's period/duty word. Channel n's control field sits at bits 15*n+9 .. 15*n: prescaler code [3:0], enable bit 4, active-level bit 5, gate bit 6, mode bit 7, pulse bit 8, raw-clock bit 9. Every field reads back as it was written, and a period/duty word reads back as last written. After reset all registers read 0.
- R2: The prescaler code selects the division. Codes 0..4 divide by 120, 180, 240, 360 and 480. Codes 8..12 divide by 12000, 24000, 36000, 48000 and 72000. Code 15 divides by 1.
- R3: While the prescaler code is 5, 6, 7, 13 or 14, the channel output stays at its inactive level.
- R4: The period/duty word holds the period minus one in [31:16] and the duty count D in [15:0], so one period lasts P = [31:16]+1 prescaled ticks. Within each period the output is active for min(D, P) ticks. D = 0 gives a constant inactive output.
- R5: A channel runs only when both its enable bit and its gate bit are 1. Otherwise its output is at the inactive level.
- R6: With the active-level bit at 1 the active level is high and the inactive level is low. With the bit at 0 both levels are swapped.
- R7: With the raw-clock bit at 1 the channel output equals the source clock, whatever the other fields hold.
- R8: A period/duty write to a stopped channel takes effect at once. A write to a running channel takes effect at the next period boundary. Ready bit 28+n reads 1 only while such an update is pending, and it rises only after a write.
- R9: Clearing the gate bit resets the channel's prescaler and period counters. After the channel is started again, its first period begins with a full active phase.
- R10: The mode and pulse bits have no effect on the output. Control-word bits that belong to no field read 0.
- R11: The two channels are independent. Settings of one channel do not change the other channel's output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Source clock, also the only register clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 4 | Byte address of the write |
| wr_data | input | 32 | Write data |
| rd_addr | input | 4 | Byte address of the read |
| rd_data | output | 32 | Read data, valid in the same cycle |
| pwm_out | output | 2 | Channel outputs, bit n for channel n |

## Verification
A shadowed period/duty write can arrive in the same clock cycle as the counter's wrap at the period boundary. The design resolves this by loading the written value straight away, so no update is left pending. The bench provokes the collision by writing a running channel with the divide-by-one prescaler at every phase offset across one period, which makes exactly one of those writes land on the wrap. For each offset it judges that the ready bit clears within one period and that the next full period shows the new duty. It also requires the ready bit to be seen set in all but at most one offset.

// File: rtl/pwm2_pkg.sv
// Package: shared field layout, prescaler code decode and the control-word
// mask for the two-channel pulse-width modulator.
// Assumes: control fields are 10 bits wide and repeat every 15 bits.
package pwm2_pkg;

    localparam int FIELD_W   = 10;
    localparam int CH_STRIDE = 15;
    localparam int RDY_BASE  = 28;
    localparam int DIV_W     = 17;

    // Per-channel control field, declared MSB first so that bit positions match the word.
    typedef struct packed {
        logic       raw_clk;
        logic       pulse;
        logic       mode;
        logic       gate;
        logic       act_hi;
        logic       en;
        logic [3:0] psc;
    } chan_cfg_t;

    // Division ratio for a prescaler code; 0 marks an invalid code.
    function automatic logic [DIV_W-1:0] psc_divisor(input logic [3:0] code);
        logic [DIV_W-1:0] d;
        case (code)
            4'd0:    d = 17'd120;
            4'd1:    d = 17'd180;
            4'd2:    d = 17'd240;
            4'd3:    d = 17'd360;
            4'd4:    d = 17'd480;
            4'd8:    d = 17'd12000;
            4'd9:    d = 17'd24000;
            4'd10:   d = 17'd36000;
            4'd11:   d = 17'd48000;
            4'd12:   d = 17'd72000;
            4'd15:   d = 17'd1;
            default: d = '0;
        endcase
        return d;
    endfunction

    // Bits of the control word that carry a field or a ready flag.
    function automatic logic [31:0] ctrl_used_mask(input int nch);
        logic [31:0] m;
        m = '0;
        for (int n = 0; n < nch; n++) begin
            m = m | (32'h3FF << (CH_STRIDE * n));
            m[RDY_BASE + n] = 1'b1;
        end
        return m;
    endfunction

endpackage

// File: rtl/pwm_prescaler.sv
// Module: coded clock prescaler. Emits a one-cycle tick every N source
// cycles, where N comes from the code table in the package.
// Assumes: clear holds the count at zero; an invalid code gives no ticks.
module pwm_prescaler
    import pwm2_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       clear,
    input  logic [3:0] code,
    output logic       valid,
    output logic       tick
);

    logic [DIV_W-1:0] divisor;
    logic [DIV_W-1:0] cnt_q;

    // Decode the code into a ratio and a validity flag.
    always_comb begin
        divisor = psc_divisor(code);
        valid   = (divisor != '0);
        tick    = !clear && valid && (cnt_q >= divisor - 1'b1);
    end

    // Count source cycles up to the ratio, restarting after each tick.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (clear || !valid || tick) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

endmodule

// File: rtl/pwm_channel.sv
// Module: period/duty engine of one channel, with a shadowed update.
// Assumes: run is high only while the channel is enabled, gated on and
// has a valid prescaler; tick comes from this channel's prescaler.
module pwm_channel #(
    parameter int CNT_W = 16
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               run,
    input  logic               tick,
    input  logic               wr,
    input  logic [2*CNT_W-1:0] wdata,
    output logic [2*CNT_W-1:0] regval,
    output logic               pending,
    output logic [CNT_W-1:0]   duty,
    output logic               wave
);

    logic [2*CNT_W-1:0] shadow_q;
    logic [CNT_W-1:0]   prd_q;
    logic [CNT_W-1:0]   dty_q;
    logic [CNT_W-1:0]   cnt_q;
    logic               pend_q;
    logic               boundary;
    logic               load_now;

    // The period ends when the last tick of the period arrives.
    always_comb begin
        boundary = run && tick && (cnt_q >= prd_q);
        load_now = !run || boundary;
        wave     = run && (cnt_q < dty_q);
    end

    // Period counter: held at zero when stopped, wraps at the boundary.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (!run) begin
            cnt_q <= '0;
        end else if (tick) begin
            cnt_q <= boundary ? '0 : cnt_q + 1'b1;
        end
    end

    // Shadow copy: always holds the last written word.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            shadow_q <= '0;
        end else if (wr) begin
            shadow_q <= wdata;
        end
    end

    // Active copy: loaded when stopped or at a boundary; a write on the boundary wins.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prd_q  <= '0;
            dty_q  <= '0;
            pend_q <= 1'b0;
        end else if (wr && load_now) begin
            prd_q  <= wdata[2*CNT_W-1:CNT_W];
            dty_q  <= wdata[CNT_W-1:0];
            pend_q <= 1'b0;
        end else if (wr) begin
            pend_q <= 1'b1;
        end else if (pend_q && load_now) begin
            prd_q  <= shadow_q[2*CNT_W-1:CNT_W];
            dty_q  <= shadow_q[CNT_W-1:0];
            pend_q <= 1'b0;
        end
    end

    assign regval  = shadow_q;
    assign pending = pend_q;
    assign duty    = dty_q;

endmodule

// File: rtl/pwm2ch_ctrl.sv
// Module: two-channel pulse-width modulator with a register write/read port.
// Assumes: a single source clock clocks the registers and feeds the raw-clock
// path; the control-word layout fits NCH <= 2 in 32 bits.
module pwm2ch_ctrl
    import pwm2_pkg::*;
#(
    parameter int NCH    = 2,
    parameter int ADDR_W = 4,
    parameter int DATA_W = 32,
    parameter int CNT_W  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [DATA_W-1:0] rd_data,
    output logic [NCH-1:0]    pwm_out
);

    localparam logic [ADDR_W-1:0] CTRL_OFS = '0;
    localparam int                WORD_W   = 2 * CNT_W;

    chan_cfg_t            cfg_q [NCH];
    logic [NCH*FIELD_W-1:0] cfg_flat;
    logic [NCH-1:0]       pend_vec;
    logic [NCH-1:0]       valid_vec;
    logic [NCH*CNT_W-1:0] duty_flat;
    logic [WORD_W-1:0]    regval [NCH];
    logic                 ctrl_wr;

    assign ctrl_wr = wr_en && (wr_addr == CTRL_OFS);

    // Control word: capture every channel's field on a control write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int n = 0; n < NCH; n++) cfg_q[n] <= '0;
        end else if (ctrl_wr) begin
            for (int n = 0; n < NCH; n++) cfg_q[n] <= chan_cfg_t'(wr_data[CH_STRIDE*n +: FIELD_W]);
        end
    end

    for (genvar n = 0; n < NCH; n++) begin : g_ch
        localparam logic [ADDR_W-1:0] CH_OFS = ADDR_W'(4 * (n + 1));
        logic tick;
        logic valid;
        logic run;
        logic wave;
        logic chan_wr;

        assign run     = cfg_q[n].en && cfg_q[n].gate && valid;
        assign chan_wr = wr_en && (wr_addr == CH_OFS);

        pwm_prescaler i_psc (
            .clk   (clk),
            .rst_n (rst_n),
            .clear (!(cfg_q[n].en && cfg_q[n].gate)),
            .code  (cfg_q[n].psc),
            .valid (valid),
            .tick  (tick)
        );

        pwm_channel #(.CNT_W(CNT_W)) i_chan (
            .clk     (clk),
            .rst_n   (rst_n),
            .run     (run),
            .tick    (tick),
            .wr      (chan_wr),
            .wdata   (wr_data[WORD_W-1:0]),
            .regval  (regval[n]),
            .pending (pend_vec[n]),
            .duty    (duty_flat[CNT_W*n +: CNT_W]),
            .wave    (wave)
        );

        // Output select: raw clock overrides, else polarity-adjusted waveform.
        always_comb begin
            if (cfg_q[n].raw_clk) pwm_out[n] = clk;
            else                  pwm_out[n] = cfg_q[n].act_hi ? wave : !wave;
        end

        assign cfg_flat[FIELD_W*n +: FIELD_W] = cfg_q[n];
        assign valid_vec[n] = valid;
    end

    // Read mux: control word with ready flags, or a channel's last written word.
    always_comb begin
        rd_data = '0;
        if (rd_addr == CTRL_OFS) begin
            for (int n = 0; n < NCH; n++) begin
                rd_data[CH_STRIDE*n +: FIELD_W] = cfg_q[n];
                rd_data[RDY_BASE + n]           = pend_vec[n];
            end
        end else begin
            for (int n = 0; n < NCH; n++) begin
                if (rd_addr == ADDR_W'(4 * (n + 1))) rd_data[WORD_W-1:0] = regval[n];
            end
        end
    end

endmodule

// File: rtl/pwm2ch_checker.sv
// Module: assertion checker for pwm2ch_ctrl, attached by bind below.
// Assumes: cfg_flat packs each channel's 10-bit control field.
module pwm2ch_checker
    import pwm2_pkg::*;
#(
    parameter int NCH    = 2,
    parameter int ADDR_W = 4,
    parameter int CNT_W  = 16
) (
    input logic                   clk,
    input logic                   rst_n,
    input logic                   wr_en,
    input logic [ADDR_W-1:0]      rd_addr,
    input logic [31:0]            rd_data,
    input logic [NCH*FIELD_W-1:0] cfg_flat,
    input logic [NCH-1:0]         pend_vec,
    input logic [NCH*CNT_W-1:0]   duty_flat,
    input logic [NCH-1:0]         pwm_out
);

    localparam logic [31:0] USED = ctrl_used_mask(NCH);

    a_r10_unused_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_addr == '0) |-> ((rd_data & ~USED) == 32'd0));

    for (genvar n = 0; n < NCH; n++) begin : g_chk
        logic [3:0] code;
        logic       en, act, gate, raw;
        logic       bad_code;
        assign code = cfg_flat[FIELD_W*n +: 4];
        assign en   = cfg_flat[FIELD_W*n + 4];
        assign act  = cfg_flat[FIELD_W*n + 5];
        assign gate = cfg_flat[FIELD_W*n + 6];
        assign raw  = cfg_flat[FIELD_W*n + 9];
        assign bad_code = (code inside {4'd5, 4'd6, 4'd7, 4'd13, 4'd14});

        a_r5_idle_inactive: assert property (@(posedge clk) disable iff (!rst_n)
            (!raw && !(en && gate)) |-> (pwm_out[n] == !act));

        a_r3_invalid_inactive: assert property (@(posedge clk) disable iff (!rst_n)
            (!raw && bad_code) |-> (pwm_out[n] == !act));

        a_r4_zero_duty: assert property (@(posedge clk) disable iff (!rst_n)
            (!raw && duty_flat[CNT_W*n +: CNT_W] == '0) |-> (pwm_out[n] == !act));

        a_r8_pend_after_write: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(pend_vec[n]) |-> $past(wr_en));
    end

endmodule

bind pwm2ch_ctrl pwm2ch_checker #(.NCH(NCH), .ADDR_W(ADDR_W), .CNT_W(CNT_W)) i_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en     (wr_en),
    .rd_addr   (rd_addr),
    .rd_data   (rd_data),
    .cfg_flat  (cfg_flat),
    .pend_vec  (pend_vec),
    .duty_flat (duty_flat),
    .pwm_out   (pwm_out)
);

// File: tb/test_pwm2ch_ctrl.sv
// Bench: vector table for waveform shape, then directed tests.
module test_pwm2ch_ctrl;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [3:0]  wr_addr = '0;
    logic [31:0] wr_data = '0;
    logic [3:0]  rd_addr = '0;
    logic [31:0] rd_data;
    logic [1:0]  pwm_out;

    int errs = 0;
    int checks = 0;
    int cyc = 0;

    always #4 clk = !clk;

    pwm2ch_ctrl i_pwm2ch_ctrl (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data), .pwm_out(pwm_out)
    );

    // Vector: ch[39] code[38:35] prd_m1[34:19] duty[18:3] act_hi[2] mode_pulse[1]
    localparam int NV = 11;
    localparam logic [39:0] VEC [NV] = '{
        {1'b0, 4'd15, 16'd9, 16'd3,  1'b1, 1'b0, 1'b0},
        {1'b0, 4'd15, 16'd9, 16'd0,  1'b1, 1'b0, 1'b0},
        {1'b0, 4'd15, 16'd9, 16'd12, 1'b1, 1'b0, 1'b0},
        {1'b1, 4'd15, 16'd4, 16'd2,  1'b0, 1'b0, 1'b0},
        {1'b0, 4'd0,  16'd3, 16'd1,  1'b1, 1'b0, 1'b0},
        {1'b1, 4'd4,  16'd1, 16'd1,  1'b1, 1'b0, 1'b0},
        {1'b0, 4'd8,  16'd1, 16'd1,  1'b1, 1'b0, 1'b0},
        {1'b1, 4'd2,  16'd2, 16'd2,  1'b0, 1'b0, 1'b0},
        {1'b0, 4'd15, 16'd0, 16'd1,  1'b1, 1'b0, 1'b0},
        {1'b1, 4'd1,  16'd0, 16'd0,  1'b0, 1'b0, 1'b0},
        {1'b0, 4'd15, 16'd9, 16'd3,  1'b1, 1'b1, 1'b0}
    };

    function automatic int bdiv(input logic [3:0] c);
        case (c)
            4'd0: return 120;    4'd1: return 180;    4'd2: return 240;
            4'd3: return 360;    4'd4: return 480;    4'd8: return 12000;
            4'd9: return 24000;  4'd10: return 36000; 4'd11: return 48000;
            4'd12: return 72000; 4'd15: return 1;     default: return 0;
        endcase
    endfunction

    function automatic logic [31:0] cword(input int ch, input logic [3:0] code, input logic en,
                                          input logic act, input logic gate, input logic mp,
                                          input logic raw);
        logic [31:0] f;
        f = {22'd0, raw, mp, mp, gate, act, en, code};
        return f << (15 * ch);
    endfunction

    task automatic chk(input string req, input longint got, input longint exp);
        checks++;
        if (got != exp) begin
            errs++;
            $display("FAIL %s: actual=%0d expected=%0d", req, got, exp);
        end
    endtask

    task automatic wr(input logic [3:0] a, input logic [31:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [3:0] a, output logic [31:0] d);
        rd_addr = a;
        #1;
        d = rd_data;
    endtask

    task automatic count_high(input int n, output int h0, output int h1);
        h0 = 0; h1 = 0;
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            if (pwm_out[0]) h0++;
            if (pwm_out[1]) h1++;
        end
    endtask

    // Watchdog: a hung run counts as a failure and still prints the summary.
    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            errs++; checks++;
            $display("FAIL watchdog: actual=%0d expected<=150000 cycles", cyc);
            $display("Result: errors=%0d of %0d checks", errs, checks);
            $finish;
        end
    end

    initial begin
        logic [31:0] d;
        int h0, h1, win, dv, hi, seen;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // Reset state (R1, R5, R6)
        rd(4'h0, d); chk("R1 reset ctrl", d, 0);
        rd(4'h4, d); chk("R1 reset ch0 word", d, 0);
        rd(4'h8, d); chk("R1 reset ch1 word", d, 0);
        chk("R5 reset outputs inactive", pwm_out, 2'b11);

        // Vector table: R2 R4 R6 R10 R11
        for (int v = 0; v < NV; v++) begin
            int ch, p, du, lim;
            logic [3:0] code;
            logic act, mp;
            ch = VEC[v][39]; code = VEC[v][38:35]; p = int'(VEC[v][34:19]) + 1;
            du = int'(VEC[v][18:3]); act = VEC[v][2]; mp = VEC[v][1];
            dv = bdiv(code);
            wr(4'h0, cword(ch, code, 1'b1, act, 1'b0, mp, 1'b0));
            wr(4'(4 * (ch + 1)), {VEC[v][34:19], VEC[v][18:3]});
            wr(4'h0, cword(ch, code, 1'b1, act, 1'b1, mp, 1'b0));
            win = 2 * p * dv;
            lim = (du < p) ? du : p;
            hi  = act ? 2 * lim * dv : win - 2 * lim * dv;
            count_high(win, h0, h1);
            chk($sformatf("R2/R4/R6/R10 vector %0d highs", v), ch ? h1 : h0, hi);
            chk($sformatf("R11 vector %0d other channel idle", v), ch ? h0 : h1, win);
        end

        // R5: enable without gate, and gate without enable
        wr(4'h4, {16'd9, 16'd5});
        wr(4'h0, cword(0, 4'd15, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0));
        count_high(40, h0, h1); chk("R5 enable only stays inactive", h0, 0);
        wr(4'h0, cword(0, 4'd15, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0));
        count_high(40, h0, h1); chk("R5 gate only stays inactive", h0, 0);

        // R3: invalid prescaler codes hold the inactive level
        foreach (VEC[k]) begin end
        for (int c = 5; c <= 14; c++) begin
            if (c > 7 && c < 13) continue;
            wr(4'h0, cword(0, 4'(c), 1'b1, 1'b1, 1'b1, 1'b0, 1'b0));
            count_high(40, h0, h1);
            chk($sformatf("R3 invalid code %0d inactive", c), h0, 0);
        end

        // R7 + R1 + R10: all bits set, raw clock on both channels
        wr(4'h0, 32'hFFFF_FFFF);
        rd(4'h0, d); chk("R1/R10 ctrl readback mask", d, 32'h01FF_83FF);
        for (int i = 0; i < 3; i++) begin
            @(negedge clk); #2; chk("R7 raw clock low phase", pwm_out, 2'b00);
            #4; chk("R7 raw clock high phase", pwm_out, 2'b11);
        end

        // R8: write to a stopped channel loads at once, no ready flag
        wr(4'h0, 32'd0);
        wr(4'h4, {16'd9, 16'd3});
        rd(4'h0, d); chk("R8 stopped write not pending", d[28], 0);
        rd(4'h4, d); chk("R1 ch0 word readback", d, {16'd9, 16'd3});
        wr(4'h0, cword(0, 4'd15, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0));

        // R8: shadowed write at every phase offset; one lands on the wrap
        seen = 0;
        for (int off = 0; off < 10; off++) begin
            int nd, k;
            nd = (off % 2 == 0) ? 7 : 3;
            repeat (off + 3) @(negedge clk);
            wr(4'h4, {16'd9, 16'(nd)});
            rd(4'h0, d);
            if (d[28]) seen++;
            k = 0;
            while (d[28] && k < 12) begin
                @(negedge clk); rd(4'h0, d); k++;
            end
            chk($sformatf("R8 ready clears within a period, offset %0d", off), d[28], 0);
            count_high(20, h0, h1);
            chk($sformatf("R8 new duty applied, offset %0d", off), h0, 2 * nd);
        end
        chk("R8 ready seen in at least 9 offsets", (seen >= 9) ? 1 : 0, 1);

        // R9: gate clear restarts counters; first period starts with full active phase
        wr(4'h0, 32'd0);
        wr(4'h4, {16'd3, 16'd1});
        wr(4'h0, cword(0, 4'd0, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0));
        repeat (203) @(negedge clk);
        wr(4'h0, cword(0, 4'd0, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0));
        repeat (5) @(negedge clk);
        wr(4'h0, cword(0, 4'd0, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0));
        hi = pwm_out[0] ? 1 : 0;
        count_high(119, h0, h1);
        chk("R9 restart active phase length", hi + h0, 120);
        @(negedge clk);
        chk("R9 active phase ends after one tick", pwm_out[0], 0);

        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end

endmodule